// File: doc/BRIEF.md
# Page Access Permission and Protection-Key Checker

This block takes the effective attributes of a translated page and one access request, and decides whether the access may proceed. It combines the page's user, writable and no-execute bits with the privilege of the access and the paging mode flags. Those flags are write protection, execute-disable enable, supervisor execute prevention, and the user and supervisor protection-key enables. A 4-bit page key selects a two-bit field in one of two 32-bit key-rights registers, and that field can further restrict the access.

The result is a read/write/execute permission mask, a fault flag and a 32-bit page-fault error code that records the cause. Two fault causes come from the page-table walk upstream (entry not present, reserved bit set) and enter as inputs. All outputs are registered: a request strobed with `req_vld` produces its response one clock later, and the response holds until the next request.

Top module: `pkc_perm_check`

## Requirements
- R1: `rsp_vld` is high in exactly the cycle after a cycle with `req_vld` high. While `req_vld` is low, `perm`, `fault` and `err_code` keep their values. After reset all outputs are zero.
- R2: A not-present input gives a fault whose error code has bit 0 (present) and bit 3 (reserved) clear. This cause takes priority over all others.
- R3: A reserved-bit input, with the entry present, gives a fault with error code bit 3 set and bit 0 clear.
- R4: A user access (`priv` = 2 or 3) to a page whose user bit is clear gives a protection fault, with error code bit 0 set.
- R5: Read is granted unless `priv` = 1 (supervisor with user-access prevention) and the page is a user page. When read is granted, write is granted if the page is writable, or if the access is supervisor (`priv` 0 or 1) and write protection is off.
- R6: Execute is granted when no-execute is clear, and either the access is user or the page is not a user page while supervisor execute prevention is on.
- R7: The key-rights source is `ukey_rights` for user pages when `ukey_en` is set, and `skey_rights` for supervisor pages when `skey_en` is set. In every other case the rights are taken as all zero.
- R8: Key field bits [2*key] and [2*key+1] apply as follows. The low bit removes read and write. When the low bit is clear, the high bit removes write if the access is user or write protection is on. If the key rights remove the requested access, the fault code sets bit 5 (key) and bit 0. A fetch (`acc_type` = 2) never gives a key fault.
- R9: If the combined mask lacks the bit of the requested access, the result is a protection fault with error code bit 0 set.
- R10: On any fault, error code bit 2 is set for user accesses and bit 1 is set for stores (`acc_type` = 1). Bits 31:6 are always zero.
- R11: On a fetch fault, error code bit 4 is set only when execute-disable enable or supervisor execute prevention is on.
- R12: Without a fault, `perm` is the combined mask (read bit 0, write bit 1, execute bit 2) and `err_code` is zero. With a fault, `perm` is zero. `acc_type` 0 is load and 3 is treated as load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe; loads the output registers |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| priv | input | 2 | 0 supervisor, 1 supervisor with user-access prevention, 2/3 user |
| pg_user | input | 1 | Effective page user bit |
| pg_write | input | 1 | Effective page writable bit |
| pg_nx | input | 1 | Effective page no-execute bit |
| mode_wp | input | 1 | Write protection applies to supervisor |
| mode_nxe | input | 1 | Execute-disable enabled |
| mode_smep | input | 1 | Supervisor execute prevention on user pages |
| ukey_en | input | 1 | User-page protection keys enabled |
| skey_en | input | 1 | Supervisor-page protection keys enabled |
| ukey_rights | input | 32 | Key rights for user pages |
| skey_rights | input | 32 | Key rights for supervisor pages |
| pkey | input | 4 | Page protection key |
| flt_notpres | input | 1 | Upstream: entry not present |
| flt_rsvd | input | 1 | Upstream: reserved bit set |
| rsp_vld | output | 1 | Response valid |
| perm | output | 3 | Granted mask: read, write, execute |
| fault | output | 1 | Access faults |
| err_code | output | 32 | Page-fault error code |

## Verification
The checker watches every cycle for the response timing and the holding of outputs between requests. It also checks the not-present encoding, the absence of key faults on fetches, the write bit on store faults and the protection fault for user accesses to supervisor pages. The selection of the key-rights source, the interplay of write protection with the key write-disable bit, and the conditional fetch bit depend on combinations of inputs. Only the bench's sweep shows those, comparing each response against an arithmetic model over all privileges, access types, page bits, mode flags and fault inputs.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
  localparam int KEY_W    = 4;
  localparam int RIGHTS_W = 2 << KEY_W;
  localparam int ERR_W    = 32;

  localparam int EC_PRES  = 0;
  localparam int EC_WR    = 1;
  localparam int EC_USR   = 2;
  localparam int EC_RSVD  = 3;
  localparam int EC_FETCH = 4;
  localparam int EC_KEY   = 5;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/pkc_base_rights.sv
module pkc_base_rights
  import pkc_pkg::*;
(
  input  logic  is_user,
  input  logic  no_usr_acc,
  input  logic  pg_user,
  input  logic  pg_write,
  input  logic  pg_nx,
  input  logic  wp,
  input  logic  smep,
  output perm_t base
);
  always_comb begin
    base.r = !(no_usr_acc && pg_user);
    base.w = base.r && (pg_write || !(is_user || wp));
    base.x = !pg_nx && (is_user || !(smep && pg_user));
  end
endmodule

// File: rtl/pkc_key_gate.sv
module pkc_key_gate
  import pkc_pkg::*;
#(
  parameter int KW = KEY_W,
  localparam int RW = 2 << KW
) (
  input  logic          pg_user,
  input  logic          is_user,
  input  logic          wp,
  input  logic          ukey_en,
  input  logic          skey_en,
  input  logic [RW-1:0] urights,
  input  logic [RW-1:0] srights,
  input  logic [KW-1:0] pkey,
  output perm_t         kmask
);
  logic [RW-1:0] rights;
  logic [1:0]    field;

  always_comb begin
    if (pg_user) rights = ukey_en ? urights : '0;
    else         rights = skey_en ? srights : '0;
    field   = rights[{pkey, 1'b0} +: 2];
    kmask.x = 1'b1;
    kmask.r = !field[0];
    kmask.w = !field[0] && !(field[1] && (is_user || wp));
  end
endmodule

// File: rtl/pkc_fault_enc.sv
module pkc_fault_enc
  import pkc_pkg::*;
(
  input  acc_e             acc,
  input  logic             is_user,
  input  logic             notpres,
  input  logic             rsvd,
  input  logic             pg_user,
  input  logic             nxe,
  input  logic             smep,
  input  perm_t            base,
  input  perm_t            kmask,
  output perm_t            perm,
  output logic             fault,
  output logic [ERR_W-1:0] code
);
  perm_t sel;
  perm_t eff;
  logic  usr_viol, key_viol, prm_viol;

  always_comb begin
    case (acc)
      ACC_STORE: sel = '{x: 1'b0, w: 1'b1, r: 1'b0};
      ACC_FETCH: sel = '{x: 1'b1, w: 1'b0, r: 1'b0};
      default:   sel = '{x: 1'b0, w: 1'b0, r: 1'b1};
    endcase
    eff      = base & kmask;
    usr_viol = is_user && !pg_user;
    key_viol = (kmask & sel) == '0;
    prm_viol = (eff & sel) == '0;
    fault    = notpres || rsvd || usr_viol || key_viol || prm_viol;
    code     = '0;
    if (notpres) begin
      code = '0;
    end else if (rsvd) begin
      code[EC_RSVD] = 1'b1;
    end else if (usr_viol) begin
      code[EC_PRES] = 1'b1;
    end else if (key_viol) begin
      code[EC_PRES] = 1'b1;
      code[EC_KEY]  = 1'b1;
    end else if (prm_viol) begin
      code[EC_PRES] = 1'b1;
    end
    if (fault) begin
      code[EC_USR]   = is_user;
      code[EC_WR]    = (acc == ACC_STORE);
      code[EC_FETCH] = (acc == ACC_FETCH) && (nxe || smep);
    end
    perm = fault ? perm_t'('0) : eff;
  end
endmodule

// File: rtl/pkc_perm_check.sv
module pkc_perm_check
  import pkc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_vld,
  input  logic [1:0]          acc_type,
  input  logic [1:0]          priv,
  input  logic                pg_user,
  input  logic                pg_write,
  input  logic                pg_nx,
  input  logic                mode_wp,
  input  logic                mode_nxe,
  input  logic                mode_smep,
  input  logic                ukey_en,
  input  logic                skey_en,
  input  logic [RIGHTS_W-1:0] ukey_rights,
  input  logic [RIGHTS_W-1:0] skey_rights,
  input  logic [KEY_W-1:0]    pkey,
  input  logic                flt_notpres,
  input  logic                flt_rsvd,
  output logic                rsp_vld,
  output logic [2:0]          perm,
  output logic                fault,
  output logic [ERR_W-1:0]    err_code
);
  logic             is_user, no_usr_acc;
  perm_t            base, kmask, perm_c;
  logic             fault_c;
  logic [ERR_W-1:0] code_c;

  perm_t            perm_q, perm_d;
  logic             fault_q, fault_d, vld_q, vld_d;
  logic [ERR_W-1:0] code_q, code_d;

  assign is_user    = priv[1];
  assign no_usr_acc = (priv == 2'd1);

  pkc_base_rights u_base (
    .is_user    (is_user),
    .no_usr_acc (no_usr_acc),
    .pg_user    (pg_user),
    .pg_write   (pg_write),
    .pg_nx      (pg_nx),
    .wp         (mode_wp),
    .smep       (mode_smep),
    .base       (base)
  );

  pkc_key_gate #(.KW(KEY_W)) u_key (
    .pg_user (pg_user),
    .is_user (is_user),
    .wp      (mode_wp),
    .ukey_en (ukey_en),
    .skey_en (skey_en),
    .urights (ukey_rights),
    .srights (skey_rights),
    .pkey    (pkey),
    .kmask   (kmask)
  );

  pkc_fault_enc u_enc (
    .acc     (acc_e'(acc_type)),
    .is_user (is_user),
    .notpres (flt_notpres),
    .rsvd    (flt_rsvd),
    .pg_user (pg_user),
    .nxe     (mode_nxe),
    .smep    (mode_smep),
    .base    (base),
    .kmask   (kmask),
    .perm    (perm_c),
    .fault   (fault_c),
    .code    (code_c)
  );

  always_comb begin
    vld_d   = req_vld;
    perm_d  = perm_q;
    fault_d = fault_q;
    code_d  = code_q;
    if (req_vld) begin
      perm_d  = perm_c;
      fault_d = fault_c;
      code_d  = code_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      perm_q  <= '0;
      fault_q <= 1'b0;
      code_q  <= '0;
    end else begin
      vld_q   <= vld_d;
      perm_q  <= perm_d;
      fault_q <= fault_d;
      code_q  <= code_d;
    end
  end

  assign rsp_vld  = vld_q;
  assign perm     = perm_q;
  assign fault    = fault_q;
  assign err_code = code_q;
endmodule

// File: rtl/pkc_checker.sv
module pkc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [1:0]  acc_type,
  input logic [1:0]  priv,
  input logic        pg_user,
  input logic        flt_notpres,
  input logic        flt_rsvd,
  input logic        rsp_vld,
  input logic [2:0]  perm,
  input logic        fault,
  input logic [31:0] err_code
);
  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld && $stable(perm) && $stable(fault) && $stable(err_code));
  // R2
  notpres_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && flt_notpres |=> fault && !err_code[0] && !err_code[3]);
  // R4
  user_on_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && priv[1] && !pg_user && !flt_notpres && !flt_rsvd |=> fault && err_code[0]);
  // R8
  fetch_nokey_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && acc_type == 2'd2 |=> !err_code[5]);
  // R10
  store_wbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && acc_type == 2'd1 |=> !fault || err_code[1]);
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> err_code[31:6] == '0);
endmodule

bind pkc_perm_check pkc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_vld     (req_vld),
  .acc_type    (acc_type),
  .priv        (priv),
  .pg_user     (pg_user),
  .flt_notpres (flt_notpres),
  .flt_rsvd    (flt_rsvd),
  .rsp_vld     (rsp_vld),
  .perm        (perm),
  .fault       (fault),
  .err_code    (err_code)
);

// File: tb/tb_pkc_perm_check.sv
module tb_pkc_perm_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [1:0]  acc_type = '0;
  logic [1:0]  priv = '0;
  logic        pg_user = 0, pg_write = 0, pg_nx = 0;
  logic        mode_wp = 0, mode_nxe = 0, mode_smep = 0, ukey_en = 0, skey_en = 0;
  logic [31:0] ukey_rights = '0, skey_rights = '0;
  logic [3:0]  pkey = '0;
  logic        flt_notpres = 0, flt_rsvd = 0;
  logic        rsp_vld;
  logic [2:0]  perm;
  logic        fault;
  logic [31:0] err_code;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pkc_perm_check dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Arithmetic model of the requirements: returns {perm, fault, code[5:0]}
  function automatic logic [9:0] model();
    logic usr, r, w, x, kr, kw, f, kf;
    logic [1:0] fld;
    logic [31:0] rt;
    logic [2:0] sel, kmask, eff;
    logic [5:0] c;
    usr = priv[1];
    r = !(priv == 2'd1 && pg_user);                       // R5
    w = r && (pg_write || !(usr || mode_wp));              // R5
    x = !pg_nx && (usr || !(mode_smep && pg_user));        // R6
    rt = pg_user ? (ukey_en ? ukey_rights : 0) : (skey_en ? skey_rights : 0); // R7
    fld = 2'((rt >> (2 * pkey)) & 3);
    kr = !fld[0];                                          // R8
    kw = !fld[0] && !(fld[1] && (usr || mode_wp));
    kmask = {1'b1, kw, kr};
    sel = (acc_type == 1) ? 3'b010 : (acc_type == 2) ? 3'b100 : 3'b001;
    eff = {x, w, r} & kmask;
    kf = (kmask & sel) == 0;
    c = 0;
    f = 1'b1;
    if (flt_notpres) c = 0;                                // R2
    else if (flt_rsvd) c = 6'b001000;                      // R3
    else if (usr && !pg_user) c = 6'b000001;               // R4
    else if (kf) c = 6'b100001;                            // R8
    else if ((eff & sel) == 0) c = 6'b000001;              // R9
    else f = 1'b0;
    if (f) begin                                           // R10 R11
      c[2] = usr;
      c[1] = (acc_type == 1);
      c[4] = (acc_type == 2) && (mode_nxe || mode_smep);
    end
    return {f ? 3'b000 : eff, f, c};                       // R12
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [9:0] e;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset rsp_vld", {31'b0, rsp_vld}, 0);
    chk("R1 reset outputs", {25'b0, perm, fault, err_code[2:0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    n = 0;
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < 4; p++)
        for (int pb = 0; pb < 8; pb++)
          for (int m = 0; m < 32; m++)
            for (int fl = 0; fl < 4; fl++) begin
              n++;
              acc_type = 2'(a); priv = 2'(p);
              {pg_user, pg_write, pg_nx} = 3'(pb);
              {mode_wp, mode_nxe, mode_smep, ukey_en, skey_en} = 5'(m);
              {flt_notpres, flt_rsvd} = 2'(fl);
              pkey = 4'(n * 7);
              ukey_rights = 32'h1B1BE4E4 ^ (32'(n) * 32'h9E3779B9);
              skey_rights = 32'hC3A5965A ^ (32'(n) * 32'h85EBCA6B);
              req_vld = 1'b1;
              e = model();
              @(negedge clk);
              chk("R1 rsp_vld", {31'b0, rsp_vld}, 1);
              chk("R5 R6 R7 R8 R12 perm", {29'b0, perm}, {29'b0, e[9:7]});
              chk("R2 R3 R4 R8 R9 fault", {31'b0, fault}, {31'b0, e[6]});
              chk("R10 R11 err_code", err_code, {26'b0, e[5:0]});
            end

    // R7 directed: rights of the other source are ignored
    acc_type = 0; priv = 2; pg_user = 1; pg_write = 1; pg_nx = 0;
    {mode_wp, mode_nxe, mode_smep} = 0; ukey_en = 1; skey_en = 1;
    flt_notpres = 0; flt_rsvd = 0; pkey = 4'd3;
    ukey_rights = 32'h0; skey_rights = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R7 user page uses user rights", {28'b0, fault, perm}, {28'b0, 1'b0, 3'b111});
    // R8 directed: store with write-disable key bit, user access
    acc_type = 1; ukey_rights = 32'h2 << 6;
    @(negedge clk);
    chk("R8 key write-disable code", err_code, 32'h27);
    // R8 fetch never key faults even with access-disable
    acc_type = 2; ukey_rights = 32'h3 << 6; mode_nxe = 1;
    @(negedge clk);
    chk("R8 fetch no key fault", {31'b0, fault}, 0);

    // R1 hold: inputs change while idle, outputs unchanged
    req_vld = 1'b0; acc_type = 1; priv = 0; pg_user = 0; flt_notpres = 1;
    @(negedge clk);
    chk("R1 idle rsp_vld", {31'b0, rsp_vld}, 0);
    chk("R1 idle hold", {28'b0, fault, perm}, {28'b0, 1'b0, 3'b100});
    @(negedge clk);
    chk("R1 idle hold err", err_code, 0);

    finish_run();
  end
endmodule